// File: doc/BRIEF.md
# Complement-Mode Adder-Subtractor

This block is a purely combinational N-bit signed adder-subtractor. One control input chooses between addition (A+B) and subtraction (A-B). A second input chooses the number system: two's complement or one's complement. For subtraction, a per-bit 2:1 multiplexer passes the bitwise inverse of B to a ripple-carry chain. In two's-complement mode the carry-in is then forced to one, which completes the negation. In one's-complement mode the carry-in stays at zero. The carry leaving the top column is then fed back into the least significant column as an end-around carry.

The block returns three results: the N-bit result word, the carry out of the top column of the main addition, and a signed-overflow flag. The overflow flag uses a rule that suits the selected number system. The block holds no state and has no clock. It is meant to sit inside a larger datapath, between registers that belong to its neighbours. The width is set by the parameter `N`, which must be at least 2 and defaults to 4.

Top module: `compl_addsub`

## Requirements
- R1: With `onesMode`=0 (two's complement) and `minus`=0, `sum` equals (opA+opB) mod 2^N and `carryOut` is bit N of opA+opB.
- R2: With `onesMode`=0 and `minus`=1, `sum` equals (opA + ~opB + 1) mod 2^N, which is opA-opB, and `carryOut` is bit N of opA + ~opB + 1. For example, with N=4, 2-3 gives 1111.
- R3: With `onesMode`=0, `overflow` is the carry out of the top column XOR the carry into the top column. This equals 1 exactly when the true signed result lies outside -2^(N-1)..2^(N-1)-1. For example, with N=4, 3+5 gives 1000 with `overflow`=1, and -3+-5 gives 1000 with `overflow`=0.
- R4: With `onesMode`=1 and `minus`=0, let w = opA+opB. Then `sum` equals (w mod 2^N) + bit N of w, taken mod 2^N (end-around carry).
- R5: With `onesMode`=1 and `minus`=1, the operand ~opB is added with carry-in 0, and the end-around carry is applied as in R4. For example, with N=4, 2-3 gives 1110 and -2-3 (1101 minus 0011) gives 1010.
- R6: With `onesMode`=1, `carryOut` is bit N of the first addition, which is the carry that wraps around. In that mode the second (wrap) addition never produces a carry of its own.
- R7: With `onesMode`=1, `overflow` is 1 exactly when opA and the effective second operand (opB, or ~opB when `minus`=1) have the same sign bit and `sum` has the other sign bit. This equals a one's-complement signed result outside -(2^(N-1)-1)..2^(N-1)-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | N | First operand |
| opB | input | N | Second operand |
| minus | input | 1 | 1 = subtract opB, 0 = add |
| onesMode | input | 1 | 0 = two's complement, 1 = one's complement |
| sum | output | N | Result word |
| carryOut | output | 1 | Carry out of the top column of the main addition |
| overflow | output | 1 | Signed overflow for the selected number system |

## Verification
The bench builds the block with the default N=4. At that width, every operand pair can be applied for each combination of mode and operation, which is 1024 cases. Each case is compared against an integer model that works on signed values. The sweep therefore covers every end-around carry case, both encodings of zero in one's complement, and the most negative two's-complement operand. A short vector table also pins down the worked 4-bit examples from the requirements.

// File: rtl/compl_addsub_pkg.sv
package compl_addsub_pkg;

  typedef enum logic {
    ARITH_TWOS = 1'b0,
    ARITH_ONES = 1'b1
  } arithModeT;

  typedef struct packed {
    logic invertB;     // pass ~opB through the operand multiplexer
    logic carryIn;     // carry into column 0 of the main chain
    logic wrapCarry;   // feed top carry back into column 0 of the result
    logic onesOvfRule; // select the sign-based overflow rule
  } addsubCtrlT;

endpackage

// File: rtl/compl_addsub_fa.sv
module compl_addsub_fa (
  input  logic x,
  input  logic y,
  input  logic cin,
  output logic s,
  output logic cout
);
  logic halfSum;
  assign halfSum = x ^ y;
  assign s       = halfSum ^ cin;
  assign cout    = (x & y) | (halfSum & cin);
endmodule

// File: rtl/compl_addsub_ctrl.sv
module compl_addsub_ctrl
  import compl_addsub_pkg::*;
(
  input  logic       minus,
  input  arithModeT  mode,
  output addsubCtrlT ctrl
);
  always_comb begin
    ctrl = '0;
    ctrl.invertB = minus;
    unique case (mode)
      ARITH_TWOS: begin
        ctrl.carryIn     = minus;
        ctrl.wrapCarry   = 1'b0;
        ctrl.onesOvfRule = 1'b0;
      end
      ARITH_ONES: begin
        ctrl.carryIn     = 1'b0;
        ctrl.wrapCarry   = 1'b1;
        ctrl.onesOvfRule = 1'b1;
      end
      default: ctrl = '0;
    endcase
  end
endmodule

// File: rtl/compl_addsub_dp.sv
module compl_addsub_dp
  import compl_addsub_pkg::*;
#(
  parameter int N = 4
) (
  input  logic [N-1:0] opA,
  input  logic [N-1:0] opB,
  input  addsubCtrlT   ctrl,
  output logic [N-1:0] sum,
  output logic         carryOut,
  output logic         overflow
);
  localparam int MSB = N - 1;

  logic [N-1:0] bSel;
  logic [N-1:0] rawSum;
  logic [N:0]   chain;
  logic [N-1:0] wrapChain;
  logic         twosOvf;
  logic         onesOvf;

  assign chain[0] = ctrl.carryIn;

  // operand multiplexer and main ripple chain
  for (genvar i = 0; i < N; i++) begin : g_col
    assign bSel[i] = ctrl.invertB ? ~opB[i] : opB[i];
    compl_addsub_fa fa_i (
      .x   (opA[i]),
      .y   (bSel[i]),
      .cin (chain[i]),
      .s   (rawSum[i]),
      .cout(chain[i+1])
    );
  end

  // end-around increment: half-adder chain on the raw result
  assign wrapChain[0] = ctrl.wrapCarry & chain[N];
  for (genvar i = 1; i < N; i++) begin : g_wrap
    assign wrapChain[i] = rawSum[i-1] & wrapChain[i-1];
  end
  assign sum = rawSum ^ wrapChain;

  assign carryOut = chain[N];
  assign twosOvf  = chain[N] ^ chain[MSB];
  assign onesOvf  = (opA[MSB] == bSel[MSB]) && (sum[MSB] != opA[MSB]);
  assign overflow = ctrl.onesOvfRule ? onesOvf : twosOvf;
endmodule

// File: rtl/compl_addsub.sv
module compl_addsub
  import compl_addsub_pkg::*;
#(
  parameter int N = 4
) (
  input  logic [N-1:0] opA,
  input  logic [N-1:0] opB,
  input  logic         minus,
  input  logic         onesMode,
  output logic [N-1:0] sum,
  output logic         carryOut,
  output logic         overflow
);
  addsubCtrlT ctrl;
  arithModeT  mode;

  assign mode = arithModeT'(onesMode);

  compl_addsub_ctrl ctrl_i (
    .minus(minus),
    .mode (mode),
    .ctrl (ctrl)
  );

  compl_addsub_dp #(.N(N)) dp_i (
    .opA     (opA),
    .opB     (opB),
    .ctrl    (ctrl),
    .sum     (sum),
    .carryOut(carryOut),
    .overflow(overflow)
  );
endmodule

// File: rtl/compl_addsub_chk.sv
module compl_addsub_chk #(
  parameter int N = 4
) (
  input logic [N-1:0] opA,
  input logic [N-1:0] opB,
  input logic         minus,
  input logic         onesMode,
  input logic [N-1:0] sum,
  input logic         carryOut,
  input logic         overflow
);
  logic [N-1:0] effB;
  logic [N:0]   wide;
  logic [N-1:0] wrapped;
  logic         sameSign;

  always_comb begin
    effB     = minus ? ~opB : opB;
    wide     = {1'b0, opA} + {1'b0, effB} + (onesMode ? '0 : {{N{1'b0}}, minus});
    wrapped  = wide[N-1:0] + {{(N-1){1'b0}}, wide[N]};
    sameSign = (opA[N-1] == effB[N-1]);
    if (!onesMode) begin
      AST_TWOS_RESULT: assert ({carryOut, sum} == wide); // R2
      AST_TWOS_OVERFLOW: assert (overflow == (sameSign && (sum[N-1] != opA[N-1]))); // R3
    end else begin
      AST_ONES_RESULT: assert (sum == wrapped); // R5
      AST_ONES_CARRY: assert (carryOut == wide[N]); // R6
      AST_ONES_OVERFLOW: assert (overflow == (sameSign && (wrapped[N-1] != opA[N-1]))); // R7
    end
  end
endmodule

bind compl_addsub compl_addsub_chk #(.N(N)) chk_i (
  .opA     (opA),
  .opB     (opB),
  .minus   (minus),
  .onesMode(onesMode),
  .sum     (sum),
  .carryOut(carryOut),
  .overflow(overflow)
);

// File: tb/compl_addsub_tb_top.sv
module compl_addsub_tb_top;
  localparam int W   = 4;
  localparam int NV  = 8;
  localparam int MAXV = (1 << (W - 1)) - 1;

  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic [W-1:0] opA, opB, sum;
  logic         minus, onesMode, carryOut, overflow;
  int checks = 0;
  int errors = 0;

  compl_addsub #(.N(W)) dut_i (
    .opA(opA), .opB(opB), .minus(minus), .onesMode(onesMode),
    .sum(sum), .carryOut(carryOut), .overflow(overflow)
  );

  // {onesMode, minus, a, b, sum, carryOut, overflow}
  localparam logic [15:0] VEC [NV] = '{
    {1'b0, 1'b1, 4'h2, 4'h3, 4'hF, 1'b0, 1'b0},  // R2 2-3 two's
    {1'b1, 1'b1, 4'h2, 4'h3, 4'hE, 1'b0, 1'b0},  // R5 2-3 one's
    {1'b0, 1'b0, 4'hD, 4'hB, 4'h8, 1'b1, 1'b0},  // R3 -3+-5
    {1'b0, 1'b0, 4'h3, 4'h5, 4'h8, 1'b0, 1'b1},  // R3 3+5
    {1'b1, 1'b1, 4'hD, 4'h3, 4'hA, 1'b1, 1'b0},  // R5 R6 -2-3 one's
    {1'b0, 1'b1, 4'hE, 4'h3, 4'hB, 1'b1, 1'b0},  // R2 -2-3 two's
    {1'b1, 1'b1, 4'h3, 4'h3, 4'hF, 1'b0, 1'b0},  // R5 3-3 gives -0
    {1'b0, 1'b1, 4'h7, 4'h8, 4'hF, 1'b0, 1'b1}   // R3 7-(-8)
  };

  task automatic check(input string req, input logic [W+1:0] act, input logic [W+1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s a=%h b=%h minus=%b ones=%b: got {sum,c,ovf}=%h expected %h",
               req, opA, opB, minus, onesMode, act, exp);
    end
  endtask

  function automatic int onesVal(input int v);
    return (v >= (1 << (W - 1))) ? -(((1 << W) - 1) - v) : v;
  endfunction

  function automatic int twosVal(input int v);
    return (v >= (1 << (W - 1))) ? v - (1 << W) : v;
  endfunction

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    opA = '0; opB = '0; minus = 1'b0; onesMode = 1'b0;
    @(negedge clk);
    check("R1 idle zero", {sum, carryOut, overflow}, '0);

    for (int k = 0; k < NV; k++) begin
      @(posedge clk);
      {onesMode, minus, opA, opB} = VEC[k][15:6];
      @(negedge clk);
      check("R2/R3/R5/R6 vector", {sum, carryOut, overflow}, VEC[k][5:0]);
    end

    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 2; s++) begin
        for (int a = 0; a < (1 << W); a++) begin
          for (int b = 0; b < (1 << W); b++) begin
            int bEff, tot, cexp, sexp, val;
            logic oexp;
            @(posedge clk);
            onesMode = m[0]; minus = s[0];
            opA = W'(a); opB = W'(b);
            bEff = s ? ((1 << W) - 1 - b) : b;
            if (m == 0) begin
              tot  = a + bEff + s;
              cexp = tot >> W;
              sexp = tot & ((1 << W) - 1);
              val  = s ? twosVal(a) - twosVal(b) : twosVal(a) + twosVal(b);
              oexp = (val > MAXV) || (val < -MAXV - 1);
            end else begin
              tot  = a + bEff;
              cexp = tot >> W;
              sexp = (tot + cexp) & ((1 << W) - 1);
              val  = onesVal(a) + onesVal(bEff);
              oexp = (val > MAXV) || (val < -MAXV);
            end
            @(negedge clk);
            if (m == 0)
              check(s ? "R2 R3 two's sub" : "R1 R3 two's add",
                    {sum, carryOut, overflow}, {W'(sexp), cexp[0], oexp});
            else
              check(s ? "R5 R6 R7 one's sub" : "R4 R6 R7 one's add",
                    {sum, carryOut, overflow}, {W'(sexp), cexp[0], oexp});
          end
        end
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule